// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Controller

This block sits in the decode stage of a five-stage in-order pipeline. For each of the two ALU operands it looks at the source register address. It compares that address with the destination of the instruction one slot ahead, now in execute, and with the destination of the instruction two slots ahead, now in memory. From the result it picks where the operand comes from: the register file, the result of the newer instruction, the result of the older instruction, or the PC or immediate path when the instruction does not read a register for that operand.

A newer instruction that is a load has no result yet. A dependency on it raises a stall. The stall freezes fetch, decode and execute and turns the memory-stage slot into a bubble. A load two slots ahead never stalls, because its data already sits in the memory-stage register.

The stall and flush outputs are combinational, so they act within the same cycle. The two operand selects are stored at the clock edge into the execute-stage control register and keep their value while a stall is active.

Top module: `hazard_fwd_unit`

## Requirements
- R1: When an operand reads a register (rs nonzero) that equals the newer instruction's destination, the newer instruction writes a register and is not a load, the operand select becomes 2'b11 (newer result) at the next rising edge.
- R2: When an operand reads a register that equals the newer instruction's destination, the newer instruction writes a register and is a load, `stall_o` is 1 in the same cycle.
- R3: A hit on the newer instruction takes priority over a hit on the older instruction for the same operand.
- R4: With no hit on the newer instruction, a match with the older instruction's destination while that instruction writes a register gives select 2'b10 (older result).
- R5: With no qualifying hit, the select is 2'b00 (register file). A destination match without the write flag does not count as a hit.
- R6: A match with the older instruction never causes a stall, whatever that instruction is.
- R7: A destination address of 0 never produces forwarding or a stall.
- R8: `stall_o` is the OR of the two operands' stall requests, and `mem_flush_o` always equals `stall_o`.
- R9: When operand A uses the PC (`a_uses_pc_i`), its select is 2'b01. When operand B uses the immediate (`b_uses_imm_i`), its select is 2'b01. A gated operand never stalls and never forwards.
- R10: While `stall_o` is 1 at a rising edge, both selects keep their value.
- R11: While `rst_n` is low at a rising edge, both selects become 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rs1_i | input | AW | Source register of operand A |
| rs2_i | input | AW | Source register of operand B |
| a_uses_pc_i | input | 1 | Operand A taken from the PC |
| b_uses_imm_i | input | 1 | Operand B taken from the immediate |
| prev_rd_i | input | AW | Destination of the instruction in execute |
| prev_wr_i | input | 1 | Instruction in execute writes a register |
| prev_load_i | input | 1 | Instruction in execute is a load |
| old_rd_i | input | AW | Destination of the instruction in memory |
| old_wr_i | input | 1 | Instruction in memory writes a register |
| stall_o | output | 1 | Hold fetch, decode and execute |
| mem_flush_o | output | 1 | Insert a bubble into the memory stage |
| sel_a_o | output | 2 | Registered operand A select |
| sel_b_o | output | 2 | Registered operand B select |

## Verification
`stall_o` and `mem_flush_o` follow the inputs within the same cycle. The bench checks them one time unit after it drives the inputs on a falling edge. The selects are due one rising edge later, so the bench checks them on the next falling edge. For a stall vector, the expected select is the value from the previous vector, because the register holds. Reset is checked the same way, one edge after `rst_n` is pulled low.

// File: rtl/hazard_pkg.sv
// Shared types for the forwarding / stall controller.
// Assumes 2-bit operand select codes that the execute stage decodes.
package hazard_pkg;

    // Execute-stage operand select codes (decoded downstream)
    typedef enum logic [1:0] {
        SRC_REG  = 2'b00,
        SRC_ALT  = 2'b01,
        SRC_OLD  = 2'b10,
        SRC_PREV = 2'b11
    } opsel_e;

    localparam int NUM_SRC = 4;

    // One-hot operand choice, bit index equals the select code
    typedef logic [NUM_SRC-1:0] onehot_t;

endpackage

// File: rtl/hazard_lane.sv
// Hazard decision for one operand.
// Compares one source address with the two older destinations and
// returns a one-hot source choice plus a stall request.
// Assumes a load flag only comes with a write flag. x0 never matches.
module hazard_lane #(
    parameter int AW = 5
) (
    input  logic [AW-1:0]           rs_i,
    input  logic                    alt_i,
    input  logic [AW-1:0]           prev_rd_i,
    input  logic                    prev_wr_i,
    input  logic                    prev_load_i,
    input  logic [AW-1:0]           old_rd_i,
    input  logic                    old_wr_i,
    output hazard_pkg::onehot_t     choice_o,
    output logic                    stall_req_o
);
    import hazard_pkg::*;

    logic prev_hit;
    logic old_hit;

    // Qualified matches against each older slot, gated by PC/imm use
    always_comb begin
        prev_hit = (rs_i == prev_rd_i) && prev_wr_i && (prev_rd_i != '0) && !alt_i;
        old_hit  = (rs_i == old_rd_i)  && old_wr_i  && (old_rd_i  != '0) && !alt_i;
    end

    // Source choice with newer-slot priority. A load hit stalls.
    always_comb begin
        choice_o    = '0;
        stall_req_o = 1'b0;
        if (alt_i) begin
            choice_o[SRC_ALT] = 1'b1;
        end else if (prev_hit && prev_load_i) begin
            choice_o[SRC_REG] = 1'b1;
            stall_req_o       = 1'b1;
        end else if (prev_hit) begin
            choice_o[SRC_PREV] = 1'b1;
        end else if (old_hit) begin
            choice_o[SRC_OLD] = 1'b1;
        end else begin
            choice_o[SRC_REG] = 1'b1;
        end
    end
endmodule

// File: rtl/sel_encode.sv
// Turns a one-hot source choice into the 2-bit execute select code.
// Assumes exactly one bit set.
module sel_encode (
    input  hazard_pkg::onehot_t choice_i,
    output logic [1:0]          code_o
);
    import hazard_pkg::*;

    // OR together the indices of the set bits
    always_comb begin
        code_o = 2'b00;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (choice_i[k]) code_o = code_o | 2'(k);
        end
    end
endmodule

// File: rtl/sel_hold_reg.sv
// Execute-stage control register for the operand selects.
// Loads every cycle, holds while stalled, clears on reset.
module sel_hold_reg #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Store the select, or keep it during a stall
    always_ff @(posedge clk) begin
        if (!rst_n)       q_o <= '0;
        else if (!hold_i) q_o <= d_i;
    end
endmodule

// File: rtl/hazard_fwd_unit.sv
// Decode-stage forwarding and load-use stall controller.
// Two operand lanes, combinational stall/flush, registered selects.
// Assumes the caller holds the fetch, decode and execute stages, and
// bubbles the memory stage, whenever stall_o is high.
module hazard_fwd_unit #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rs1_i,
    input  logic [AW-1:0] rs2_i,
    input  logic          a_uses_pc_i,
    input  logic          b_uses_imm_i,
    input  logic [AW-1:0] prev_rd_i,
    input  logic          prev_wr_i,
    input  logic          prev_load_i,
    input  logic [AW-1:0] old_rd_i,
    input  logic          old_wr_i,
    output logic          stall_o,
    output logic          mem_flush_o,
    output logic [1:0]    sel_a_o,
    output logic [1:0]    sel_b_o
);
    import hazard_pkg::*;

    localparam int LANES = 2;

    logic [AW-1:0] lane_rs   [LANES];
    logic          lane_alt  [LANES];
    onehot_t       lane_pick [LANES];
    logic [LANES-1:0] lane_stall;
    logic [1:0]    lane_code [LANES];
    logic [1:0]    lane_q    [LANES];

    // Route the per-operand inputs into lane arrays
    always_comb begin
        lane_rs[0]  = rs1_i;
        lane_rs[1]  = rs2_i;
        lane_alt[0] = a_uses_pc_i;
        lane_alt[1] = b_uses_imm_i;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        hazard_lane #(.AW(AW)) u_lane (
            .rs_i        (lane_rs[g]),
            .alt_i       (lane_alt[g]),
            .prev_rd_i   (prev_rd_i),
            .prev_wr_i   (prev_wr_i),
            .prev_load_i (prev_load_i),
            .old_rd_i    (old_rd_i),
            .old_wr_i    (old_wr_i),
            .choice_o    (lane_pick[g]),
            .stall_req_o (lane_stall[g])
        );

        sel_encode u_enc (
            .choice_i (lane_pick[g]),
            .code_o   (lane_code[g])
        );

        sel_hold_reg #(.W(2)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .hold_i (stall_o),
            .d_i    (lane_code[g]),
            .q_o    (lane_q[g])
        );
    end

    // Global stall and memory-stage bubble
    always_comb begin
        stall_o     = |lane_stall;
        mem_flush_o = stall_o;
    end

    // Registered selects to the ports
    always_comb begin
        sel_a_o = lane_q[0];
        sel_b_o = lane_q[1];
    end
endmodule

// File: rtl/hazard_fwd_unit_chk.sv
// Property checker for hazard_fwd_unit, attached by bind.
module hazard_fwd_unit_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] rs1_i,
    input logic [AW-1:0] rs2_i,
    input logic          a_uses_pc_i,
    input logic          b_uses_imm_i,
    input logic [AW-1:0] prev_rd_i,
    input logic          prev_wr_i,
    input logic          prev_load_i,
    input logic [AW-1:0] old_rd_i,
    input logic          old_wr_i,
    input logic          stall_o,
    input logic          mem_flush_o,
    input logic [1:0]    sel_a_o,
    input logic [1:0]    sel_b_o
);
    logic a_prev_hit;
    // Newer-slot hit seen by operand A
    always_comb a_prev_hit = !a_uses_pc_i && (rs1_i == prev_rd_i) && prev_wr_i && (prev_rd_i != '0);

    assert_prev_fwd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && a_prev_hit && !prev_load_i) |=> (sel_a_o == 2'b11));

    assert_load_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (a_prev_hit && prev_load_i) |-> stall_o);

    assert_no_old_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (prev_load_i && prev_wr_i && prev_rd_i != '0));

    assert_flush_eq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_flush_o == stall_o);

    assert_pc_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && a_uses_pc_i) |=> (sel_a_o == 2'b01));

    assert_imm_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && b_uses_imm_i) |=> (sel_b_o == 2'b01));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> ($stable(sel_a_o) && $stable(sel_b_o)));

    assert_zero_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && !a_uses_pc_i && prev_rd_i == '0 && old_rd_i == '0) |=> (sel_a_o == 2'b00));
endmodule

bind hazard_fwd_unit hazard_fwd_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_hazard_fwd_unit.sv
module test_hazard_fwd_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] rs1_i = '0, rs2_i = '0, prev_rd_i = '0, old_rd_i = '0;
    logic       a_uses_pc_i = 1'b0, b_uses_imm_i = 1'b0;
    logic       prev_wr_i = 1'b0, prev_load_i = 1'b0, old_wr_i = 1'b0;
    logic       stall_o, mem_flush_o;
    logic [1:0] sel_a_o, sel_b_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hazard_fwd_unit #(.AW(5)) i_hazard_fwd_unit (.*);

    typedef struct packed {
        logic [4:0] rs1, rs2;
        logic       pc, imm;
        logic [4:0] prd;
        logic       pwr, pld;
        logic [4:0] ord;
        logic       owr, stl;
        logic [1:0] ea, eb;
    } vec_t;

    localparam int NV = 13;
    // Expected selects for stall rows are unused: the bench expects the held value
    localparam vec_t TBL [NV] = '{
        '{5'd1,  5'd2,  1'b0, 1'b0, 5'd3,  1'b1, 1'b0, 5'd4,  1'b1, 1'b0, 2'b00, 2'b00}, // R5
        '{5'd3,  5'd2,  1'b0, 1'b0, 5'd3,  1'b1, 1'b0, 5'd4,  1'b1, 1'b0, 2'b11, 2'b00}, // R1
        '{5'd1,  5'd4,  1'b0, 1'b0, 5'd3,  1'b1, 1'b0, 5'd4,  1'b1, 1'b0, 2'b00, 2'b10}, // R4
        '{5'd5,  5'd5,  1'b0, 1'b0, 5'd5,  1'b1, 1'b0, 5'd5,  1'b1, 1'b0, 2'b11, 2'b11}, // R3
        '{5'd6,  5'd7,  1'b0, 1'b0, 5'd6,  1'b0, 1'b0, 5'd6,  1'b1, 1'b0, 2'b10, 2'b00}, // R5 R4
        '{5'd8,  5'd9,  1'b0, 1'b0, 5'd9,  1'b1, 1'b0, 5'd8,  1'b0, 1'b0, 2'b00, 2'b11}, // R5 R1
        '{5'd0,  5'd0,  1'b0, 1'b0, 5'd0,  1'b1, 1'b1, 5'd0,  1'b1, 1'b0, 2'b00, 2'b00}, // R7
        '{5'd3,  5'd3,  1'b1, 1'b1, 5'd3,  1'b1, 1'b1, 5'd3,  1'b1, 1'b0, 2'b01, 2'b01}, // R9
        '{5'd10, 5'd11, 1'b0, 1'b0, 5'd10, 1'b1, 1'b1, 5'd4,  1'b1, 1'b1, 2'b00, 2'b00}, // R2 R10
        '{5'd1,  5'd10, 1'b0, 1'b0, 5'd10, 1'b1, 1'b1, 5'd4,  1'b1, 1'b1, 2'b00, 2'b00}, // R8
        '{5'd10, 5'd12, 1'b0, 1'b0, 5'd10, 1'b1, 1'b1, 5'd12, 1'b1, 1'b1, 2'b00, 2'b00}, // R3 R2
        '{5'd12, 5'd13, 1'b0, 1'b1, 5'd13, 1'b1, 1'b1, 5'd12, 1'b1, 1'b0, 2'b10, 2'b01}, // R6 R9
        '{5'd14, 5'd15, 1'b0, 1'b0, 5'd3,  1'b1, 1'b0, 5'd4,  1'b1, 1'b0, 2'b00, 2'b00}  // R5
    };

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        rs1_i = v.rs1; rs2_i = v.rs2; a_uses_pc_i = v.pc; b_uses_imm_i = v.imm;
        prev_rd_i = v.prd; prev_wr_i = v.pwr; prev_load_i = v.pld;
        old_rd_i = v.ord; old_wr_i = v.owr;
    endtask

    initial begin
        logic [1:0] ea, eb;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R11 reset sel_a", sel_a_o, 2'b00);
        check("R11 reset sel_b", sel_b_o, 2'b00);
        rst_n = 1'b1;
        ea = 2'b00; eb = 2'b00;
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            #1;
            check("R2 R8 stall", {1'b0, stall_o}, {1'b0, TBL[i].stl});
            check("R8 flush", {1'b0, mem_flush_o}, {1'b0, TBL[i].stl});
            if (!TBL[i].stl) begin
                ea = TBL[i].ea;
                eb = TBL[i].eb;
            end
            @(posedge clk);
            @(negedge clk);
            check("R1 R3 R4 R5 R7 R9 R10 sel_a", sel_a_o, ea);
            check("R1 R3 R4 R5 R6 R9 R10 sel_b", sel_b_o, eb);
        end
        // R11: reset clears non-zero selects
        drive(TBL[3]);
        @(posedge clk);
        @(negedge clk);
        check("R3 sel_a before reset", sel_a_o, 2'b11);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R11 sel_a after reset", sel_a_o, 2'b00);
        check("R11 sel_b after reset", sel_b_o, 2'b00);
        // R10: stall held across several edges keeps selects
        rst_n = 1'b1;
        drive(TBL[1]);
        @(posedge clk);
        @(negedge clk);
        drive(TBL[8]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 held sel_a", sel_a_o, 2'b11);
        check("R10 held sel_b", sel_b_o, 2'b00);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule